// File: doc/BRIEF.md
# NAND Sector Single-Error Code Checker

This block checks the three-byte Hamming check code of each 512-byte sub-block of a NAND page. For every sub-block it takes the code read back from the spare area and the code computed over the data just read. It classifies the pair as clean, correctable or uncorrectable. When exactly one data bit is wrong, it reports which byte and which bit must be flipped. A separate agent applies that flip to the sector memory.

A page is either a single sub-block or four sub-blocks, as in a 2048-byte page. Software or a controller presents every code of the page at once on two buses and pulses `start`. The checker copies both buses into its own registers. It then walks the sub-blocks in ascending order, one per cycle, and emits one registered result per sub-block. The walk ends after the last sub-block or at the first uncorrectable one.

An erased page reads back an all-ones stored code while the engine computes all zeros. The checker treats that exact pair as clean and does not report an error for it.

Top module: `nand_ecc_checker`

## Requirements
- R1: After a synchronous reset, `busy`, `res_valid`, `fix_strobe` and `res_last` are 0 and `res_status` is 0 (clean).
- R2: A sub-block whose stored and computed codes are equal yields status 0 (clean), with `fix_strobe` low and `fix_byte`/`fix_bit` equal to 0.
- R3: Each code is 24 bits, with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. Let A = {byte offset B (9 bits), bit index b (3 bits)} be the 12-bit address of a single flipped data bit. For each group k = 0..11, the codes differ in the "odd" bit when A[k] = 1 and in the "even" bit when A[k] = 0. The even bit of group k is code bit k for k < 8 and code bit 16+(k-8) otherwise. The odd bit of group k is code bit 8+k for k < 8 and code bit 20+(k-8) otherwise. Such a difference, which has syndrome weight 12, yields status 1 (corrected), `fix_strobe` high, `fix_byte` = B and `fix_bit` = b. For every status other than corrected, `fix_byte` and `fix_bit` are 0.
- R4: A difference of syndrome weight 1 or 11 yields status 2 (uncorrectable).
- R5: Any other nonzero difference whose weight is not 12 yields status 2, unless R6 applies.
- R6: A stored code of 24'hFFFFFF together with a computed code of 24'h000000 yields status 0 (erased page). Any other pair of weight 24 or 23 is uncorrectable.
- R7: With `quad_page` = 1, four results appear on four consecutive cycles, with `res_blk` = 0, 1, 2, 3. Sub-block i takes its codes from bits [24i+23:24i] of each bus.
- R8: The walk stops at the first uncorrectable sub-block. That result carries `res_last`, and no further `res_valid` follows it.
- R9: With `quad_page` = 0, exactly one result appears, for sub-block 0, with `res_last` set. The codes in the upper lanes are ignored.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The results of the ongoing walk come from the codes captured when that walk started.
- R11: The first result is presented in the cycle after the clock edge that takes `start`, and each later result follows one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin checking a page; taken only while idle |
| quad_page | input | 1 | 1 = four sub-blocks, 0 = one sub-block |
| stored_codes | input | MAX_BLKS*24 | Codes read from the spare area, one 24-bit lane per sub-block |
| calc_codes | input | MAX_BLKS*24 | Codes computed over the read data, same lane layout |
| busy | output | 1 | A walk is in progress |
| res_valid | output | 1 | One-cycle pulse per checked sub-block |
| res_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| res_blk | output | BLK_W | Index of the sub-block this result belongs to |
| fix_byte | output | 9 | Byte offset within the sub-block to flip |
| fix_bit | output | 3 | Bit index within that byte to flip |
| fix_strobe | output | 1 | High with a corrected result |
| res_last | output | 1 | Marks the final result of the walk |

## Verification
The bench builds the checker with the default of four lanes, so it can reach both page sizes. It can also reach the early stop inside a four-lane walk and the rule that unused upper lanes are ignored in single mode. The single-lane table derives every expected byte and bit offset from a Hamming address pattern built in the bench. The table covers both address extremes, syndrome weights 1, 2, 11, 23 and 24, and the erased pair. Directed runs then check result ordering, the early stop, the latency and a `start` pulse that arrives mid-walk while the input codes change at the same time.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

    localparam int CODE_W     = 24;
    localparam int SYN_W      = 24;
    localparam int OFS_W      = 9;
    localparam int BIT_W      = 3;
    localparam int FIX_WEIGHT = 12;
    localparam int WGT_W      = $clog2(SYN_W + 1);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_FATAL = 2'd2
    } chk_status_e;

    typedef struct packed {
        logic [7:0] hi;   // byte 2
        logic [7:0] mid;  // byte 1
        logic [7:0] lo;   // byte 0
    } code_t;

    typedef struct packed {
        chk_status_e       status;
        logic [OFS_W-1:0]  byte_ofs;
        logic [BIT_W-1:0]  bit_idx;
    } verdict_t;

    // Regroup a raw code into interleaved even/odd parity pairs.
    // The raw layout keeps the even groups 0..7 in byte 0, the odd
    // groups 0..7 in byte 1, and the even/odd groups 8..11 in the low
    // and high nibbles of byte 2. The result pairs them as
    //   lo  = groups 3..6, mid = groups 7..10, hi = groups 11, 0..2.
    // The format calls for an inversion after regrouping and another
    // one before comparison; the two cancel, so neither appears here.
    function automatic code_t to_plane(code_t c);
        code_t p;
        p.lo  = {c.mid[6], c.lo[6], c.mid[5], c.lo[5],
                 c.mid[4], c.lo[4], c.mid[3], c.lo[3]};
        p.mid = {c.hi[6],  c.hi[2], c.hi[5],  c.hi[1],
                 c.hi[4],  c.hi[0], c.mid[7], c.lo[7]};
        p.hi  = {c.mid[2], c.lo[2], c.mid[1], c.lo[1],
                 c.mid[0], c.lo[0], c.hi[7],  c.hi[3]};
        return p;
    endfunction

    // Reorder a regrouped difference so that bit 2k is the even and
    // bit 2k+1 the odd parity of group k.
    function automatic logic [SYN_W-1:0] order_syndrome(code_t x);
        return {x.hi[1:0], x.mid, x.lo, x.hi[7:2]};
    endfunction

endpackage

// File: rtl/ecc_syndrome_unit.sv
module ecc_syndrome_unit
    import ecc_chk_pkg::*;
(
    input  code_t             stored_code,
    input  code_t             calc_code,
    output logic [SYN_W-1:0]  syndrome,
    output logic              codes_equal,
    output logic              erased_pair
);

    code_t plane_st;
    code_t plane_ca;
    code_t plane_x;

    always_comb begin
        plane_st    = to_plane(stored_code);
        plane_ca    = to_plane(calc_code);
        plane_x     = plane_st ^ plane_ca;
        syndrome    = order_syndrome(plane_x);
        codes_equal = (stored_code == calc_code);
        erased_pair = (stored_code == code_t'({CODE_W{1'b1}}))
                    && (plane_ca == code_t'('0));
    end

endmodule

// File: rtl/ecc_verdict.sv
module ecc_verdict
    import ecc_chk_pkg::*;
(
    input  logic [SYN_W-1:0]  syndrome,
    input  logic              codes_equal,
    input  logic              erased_pair,
    output verdict_t          verdict
);

    logic [WGT_W-1:0] weight;
    logic [OFS_W-1:0] ofs_bits;
    logic [BIT_W-1:0] idx_bits;

    // Odd-parity members carry the error address, high group first.
    always_comb begin
        for (int i = 0; i < OFS_W; i++) begin
            ofs_bits[i] = syndrome[2*(i+BIT_W)+1];
        end
        for (int j = 0; j < BIT_W; j++) begin
            idx_bits[j] = syndrome[2*j+1];
        end
    end

    always_comb begin
        weight           = WGT_W'($countones(syndrome));
        verdict.status   = ST_FATAL;
        verdict.byte_ofs = '0;
        verdict.bit_idx  = '0;
        if (codes_equal) begin
            verdict.status = ST_CLEAN;
        end else if (weight == WGT_W'(FIX_WEIGHT)) begin
            verdict.status   = ST_FIXED;
            verdict.byte_ofs = ofs_bits;
            verdict.bit_idx  = idx_bits;
        end else if (weight == WGT_W'(1) || weight == WGT_W'(11)) begin
            verdict.status = ST_FATAL;
        end else if (erased_pair) begin
            verdict.status = ST_CLEAN;
        end
    end

endmodule

// File: rtl/ecc_walk.sv
module ecc_walk
    import ecc_chk_pkg::*;
#(
    parameter int MAX_BLKS = 4,
    localparam int BLK_W   = (MAX_BLKS > 1) ? $clog2(MAX_BLKS) : 1,
    localparam int BUS_W   = MAX_BLKS * CODE_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              quad_page,
    input  logic [BUS_W-1:0]  stored_codes,
    input  logic [BUS_W-1:0]  calc_codes,
    input  logic              stop,
    output logic              run,
    output logic [BLK_W-1:0]  idx,
    output logic              cur_last,
    output code_t             cur_stored,
    output code_t             cur_calc
);

    logic [BUS_W-1:0] st_q;
    logic [BUS_W-1:0] ca_q;
    logic [BLK_W-1:0] last_idx;

    assign cur_last   = (idx == last_idx);
    assign cur_stored = code_t'(st_q[idx*CODE_W +: CODE_W]);
    assign cur_calc   = code_t'(ca_q[idx*CODE_W +: CODE_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
            st_q     <= '0;
            ca_q     <= '0;
        end else if (!run) begin
            if (start) begin
                run      <= 1'b1;
                idx      <= '0;
                last_idx <= quad_page ? BLK_W'(MAX_BLKS - 1) : '0;
                st_q     <= stored_codes;
                ca_q     <= calc_codes;
            end
        end else begin
            if (cur_last || stop) begin
                run <= 1'b0;
            end else begin
                idx <= idx + BLK_W'(1);
            end
        end
    end

    // R11: an idle start opens the walk at sub-block 0.
    p_start_opens_r11: assert property (@(posedge clk) disable iff (rst)
        (!run && start) |=> (run && idx == '0));

    // R10: a start during a walk does not restart it.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (run && start && !cur_last && !stop) |=> (run && idx == $past(idx) + BLK_W'(1)));

endmodule

// File: rtl/ecc_result_reg.sv
module ecc_result_reg
    import ecc_chk_pkg::*;
#(
    parameter int BLK_W = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BLK_W-1:0]  idx,
    input  logic              cur_last,
    input  verdict_t          verdict,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [BLK_W-1:0]  res_blk,
    output logic [OFS_W-1:0]  fix_byte,
    output logic [BIT_W-1:0]  fix_bit,
    output logic              fix_strobe,
    output logic              res_last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_status <= ST_CLEAN;
            res_blk    <= '0;
            fix_byte   <= '0;
            fix_bit    <= '0;
            fix_strobe <= 1'b0;
            res_last   <= 1'b0;
        end else begin
            res_valid  <= run;
            fix_strobe <= run && (verdict.status == ST_FIXED);
            res_last   <= run && (cur_last || verdict.status == ST_FATAL);
            if (run) begin
                res_status <= verdict.status;
                res_blk    <= idx;
                fix_byte   <= verdict.byte_ofs;
                fix_bit    <= verdict.bit_idx;
            end
        end
    end

    // R3: a correction strobe only accompanies a corrected result.
    p_fix_is_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        fix_strobe |-> (res_valid && res_status == ST_FIXED));

    // R8: an uncorrectable result always closes the walk.
    p_fatal_closes_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == ST_FATAL) |-> res_last);

    // R8: nothing follows the closing result.
    p_quiet_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        res_last |=> !res_valid);

    // R7: results of one walk arrive back to back in ascending order.
    p_blk_step_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_last) |=> (res_valid && res_blk == $past(res_blk) + BLK_W'(1)));

endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker
    import ecc_chk_pkg::*;
#(
    parameter int MAX_BLKS = 4,
    localparam int BLK_W   = (MAX_BLKS > 1) ? $clog2(MAX_BLKS) : 1,
    localparam int BUS_W   = MAX_BLKS * CODE_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              quad_page,
    input  logic [BUS_W-1:0]  stored_codes,
    input  logic [BUS_W-1:0]  calc_codes,
    output logic              busy,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [BLK_W-1:0]  res_blk,
    output logic [OFS_W-1:0]  fix_byte,
    output logic [BIT_W-1:0]  fix_bit,
    output logic              fix_strobe,
    output logic              res_last
);

    logic              run;
    logic [BLK_W-1:0]  idx;
    logic              cur_last;
    code_t             cur_stored;
    code_t             cur_calc;
    logic [SYN_W-1:0]  syndrome;
    logic              codes_equal;
    logic              erased_pair;
    verdict_t          verdict;
    logic              stop;

    assign stop = (verdict.status == ST_FATAL);
    assign busy = run;

    ecc_walk #(.MAX_BLKS(MAX_BLKS)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .quad_page    (quad_page),
        .stored_codes (stored_codes),
        .calc_codes   (calc_codes),
        .stop         (stop),
        .run          (run),
        .idx          (idx),
        .cur_last     (cur_last),
        .cur_stored   (cur_stored),
        .cur_calc     (cur_calc)
    );

    ecc_syndrome_unit u_syn (
        .stored_code  (cur_stored),
        .calc_code    (cur_calc),
        .syndrome     (syndrome),
        .codes_equal  (codes_equal),
        .erased_pair  (erased_pair)
    );

    ecc_verdict u_verdict (
        .syndrome     (syndrome),
        .codes_equal  (codes_equal),
        .erased_pair  (erased_pair),
        .verdict      (verdict)
    );

    ecc_result_reg #(.BLK_W(BLK_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .idx          (idx),
        .cur_last     (cur_last),
        .verdict      (verdict),
        .res_valid    (res_valid),
        .res_status   (res_status),
        .res_blk      (res_blk),
        .fix_byte     (fix_byte),
        .fix_bit      (fix_bit),
        .fix_strobe   (fix_strobe),
        .res_last     (res_last)
    );

endmodule

// File: tb/nand_ecc_checker_test.sv
module nand_ecc_checker_test;

    localparam int NB   = 4;
    localparam int BW   = 2;
    localparam int BUSW = NB * 24;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            quad_page = 1'b0;
    logic [BUSW-1:0] stored_codes = '0;
    logic [BUSW-1:0] calc_codes = '0;
    logic            busy, res_valid, fix_strobe, res_last;
    logic [1:0]      res_status;
    logic [BW-1:0]   res_blk;
    logic [8:0]      fix_byte;
    logic [2:0]      fix_bit;

    always #4 clk = ~clk;   // 125 MHz

    nand_ecc_checker #(.MAX_BLKS(NB)) uut (
        .clk(clk), .rst(rst), .start(start), .quad_page(quad_page),
        .stored_codes(stored_codes), .calc_codes(calc_codes),
        .busy(busy), .res_valid(res_valid), .res_status(res_status),
        .res_blk(res_blk), .fix_byte(fix_byte), .fix_bit(fix_bit),
        .fix_strobe(fix_strobe), .res_last(res_last)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Code difference caused by a single flipped data bit (see R3).
    function automatic logic [23:0] em(input int b_ofs, input int b_idx);
        logic [11:0] a;
        logic [23:0] m;
        a = {b_ofs[8:0], b_idx[2:0]};
        m = '0;
        for (int k = 0; k < 12; k++) begin
            if (a[k]) m[(k < 8) ? 8 + k : 20 + (k - 8)] = 1'b1;
            else      m[(k < 8) ? k : 16 + (k - 8)] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic [23:0] st;
        logic [23:0] mask;
        logic [1:0]  es;
        logic [8:0]  eb;
        logic [2:0]  ebit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{24'h123456, 24'h000000,                         2'd0, 9'd0,   3'd0},
        '{24'h0A5C33, em(0, 0),                           2'd1, 9'd0,   3'd0},
        '{24'h777777, em(511, 7),                         2'd1, 9'd511, 3'd7},
        '{24'h3C3C3C, em(300, 4),                         2'd1, 9'd300, 3'd4},
        '{24'h00FF00, 24'h000100,                         2'd2, 9'd0,   3'd0},
        '{24'h5A5A5A, em(77, 6) & (em(77, 6) - 24'd1),    2'd2, 9'd0,   3'd0},
        '{24'h112233, 24'h000003,                         2'd2, 9'd0,   3'd0},
        '{24'hFFFFFF, 24'hFFFFFF,                         2'd0, 9'd0,   3'd0},
        '{24'hFFFFFF, 24'hFFFFFE,                         2'd2, 9'd0,   3'd0},
        '{24'h000000, 24'hFFFFFF,                         2'd2, 9'd0,   3'd0}
    };

    int        got_n;
    int        first_at;
    logic [1:0] g_st [8];
    logic [8:0] g_by [8];
    logic [2:0] g_bi [8];
    logic [BW-1:0] g_bk [8];
    logic       g_fx [8];
    logic       g_ls [8];

    task automatic run_page(input logic quad, input logic [BUSW-1:0] st,
                            input logic [BUSW-1:0] ca, input bit poke);
        got_n = 0;
        first_at = -1;
        @(negedge clk);
        quad_page    = quad;
        stored_codes = st;
        calc_codes   = ca;
        start        = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (res_valid) begin
                if (first_at < 0) first_at = i;
                if (got_n < 8) begin
                    g_st[got_n] = res_status; g_by[got_n] = fix_byte;
                    g_bi[got_n] = fix_bit;    g_bk[got_n] = res_blk;
                    g_fx[got_n] = fix_strobe; g_ls[got_n] = res_last;
                end
                got_n++;
            end
            if (i == 0 && poke) begin
                start        = 1'b1;
                quad_page    = 1'b0;
                stored_codes = {NB{24'h000000}};
                calc_codes   = {NB{24'h000001}};
            end else begin
                start = 1'b0;
            end
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    logic [BUSW-1:0] q_st, q_ca;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0,       "R1 busy",   busy, 0);
        check(res_valid == 1'b0,  "R1 valid",  res_valid, 0);
        check(fix_strobe == 1'b0, "R1 strobe", fix_strobe, 0);
        check(res_last == 1'b0,   "R1 last",   res_last, 0);
        check(res_status == 2'd0, "R1 status", res_status, 0);
        rst = 1'b0;

        // Table walk: single sub-block pages (R2..R6)
        for (int v = 0; v < NV; v++) begin
            run_page(1'b0, {72'h0, VT[v].st}, {72'h0, VT[v].st ^ VT[v].mask}, 1'b0);
            check(got_n == 1,            $sformatf("R2-R6 vec%0d count", v), got_n, 1);
            check(g_st[0] == VT[v].es,   $sformatf("R3/R4/R5/R6 vec%0d status", v), g_st[0], VT[v].es);
            check(g_by[0] == VT[v].eb,   $sformatf("R3 vec%0d byte", v), g_by[0], VT[v].eb);
            check(g_bi[0] == VT[v].ebit, $sformatf("R3 vec%0d bit", v), g_bi[0], VT[v].ebit);
            check(g_fx[0] == (VT[v].es == 2'd1), $sformatf("R2 R3 vec%0d strobe", v),
                  g_fx[0], VT[v].es == 2'd1);
        end

        // R7 + R11: four sub-blocks with mixed outcomes
        q_st = {24'h246802, 24'hFFFFFF, 24'h0F0F0F, 24'hA1B2C3};
        q_ca = {24'h246802 ^ em(100, 5), 24'h000000, 24'h0F0F0F ^ em(3, 2), 24'hA1B2C3};
        run_page(1'b1, q_st, q_ca, 1'b0);
        check(got_n == 4,    "R7 count", got_n, 4);
        check(first_at == 1, "R11 latency", first_at, 1);
        for (int i = 0; i < 4; i++) begin
            check(g_bk[i] == BW'(i), "R7 blk order", g_bk[i], i);
            check(g_ls[i] == (i == 3), "R7 last flag", g_ls[i], i == 3);
        end
        check(g_st[0] == 2'd0 && g_st[1] == 2'd1 && g_st[2] == 2'd0 && g_st[3] == 2'd1,
              "R7 statuses", {g_st[0], g_st[1], g_st[2], g_st[3]}, 8'b00010001);
        check(g_by[1] == 9'd3 && g_bi[1] == 3'd2, "R7 R3 blk1 address", {g_by[1], g_bi[1]}, {9'd3, 3'd2});
        check(g_by[3] == 9'd100 && g_bi[3] == 3'd5, "R7 R3 blk3 address", {g_by[3], g_bi[3]}, {9'd100, 3'd5});

        // R8: stop at the first uncorrectable sub-block
        run_page(1'b1, {24'h1, 24'h2, 24'h0, 24'h5555AA},
                 {24'h1, 24'h2, 24'h000001, 24'h5555AA ^ em(9, 1)}, 1'b0);
        check(got_n == 2,        "R8 count", got_n, 2);
        check(g_st[1] == 2'd2,   "R8 status", g_st[1], 2);
        check(g_ls[1] == 1'b1,   "R8 last", g_ls[1], 1);
        check(g_st[0] == 2'd1 && g_ls[0] == 1'b0, "R8 first ok", g_st[0], 1);

        // R9: single mode ignores the upper lanes
        run_page(1'b0, {24'h0, 24'h0, 24'h0, 24'h777000},
                 {24'h1, 24'h1, 24'h1, 24'h777000}, 1'b0);
        check(got_n == 1, "R9 count", got_n, 1);
        check(g_bk[0] == '0 && g_ls[0] && g_st[0] == 2'd0, "R9 result", g_st[0], 0);

        // R10: start during a walk is ignored, captured codes are kept
        run_page(1'b1, q_st, q_ca, 1'b1);
        check(got_n == 4, "R10 count", got_n, 4);
        check(g_st[1] == 2'd1 && g_st[3] == 2'd1 && g_st[0] == 2'd0,
              "R10 captured codes", g_st[1], 1);
        check(g_by[3] == 9'd100, "R10 blk3 byte", g_by[3], 100);
        check(busy == 1'b0, "R10 idle after walk", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule